// File: doc/BRIEF.md
# Serial Converter Output Shift Model

This block is the digital half of a serial sampling converter. It can be built as an emulator or used as a responder inside a test environment. A host selects the block with an active-low select line and clocks it with a serial clock. On the select falling edge the block captures a parallel sample word, enters hold, and enables its data output. It then shifts out a 16-bit frame. The frame has four zero bits, then the sample most significant bit first, then zero padding up to sixteen bits.

Each serial clock falling edge advances the frame by one bit. The output enable, the return from hold to track, and the verdict on the conversion all depend on how many falling edges were seen since select fell. Those counts depend on the resolution, which can be 12, 10 or 8 bits.

The select and serial clock inputs must be synchronous to the block clock. Every output changes one block clock after the input edge that causes it.

Top module: `adc_shift_model`

## Requirements
- R1: One cycle after `cs_n` falls, the block captures `sample_word`, and `sdo_oe` and `hold` go to 1 while `done` and `aborted` go to 0. Later changes of `sample_word` in the same frame have no effect on the frame.
- R2: Frame bit k (k = 0..15) is visible on `sdo` one cycle after the k-th falling edge of `sclk`, with bit 0 shown right after select. Bits 0..3 are 0 and bits 4..4+RES_BITS-1 are the sample, most significant bit first. `sdo` reads 0 whenever `sdo_oe` is 0.
- R3: Frame bits after the sample are 0: two of them at 10-bit resolution and four at 8-bit resolution.
- R4: `sdo_oe` goes to 0 one cycle after the 16th `sclk` falling edge of a frame.
- R5: One cycle after `cs_n` rises, `sdo_oe` and `hold` are 0, whatever the edge count.
- R6: `hold` goes to 0 one cycle after the first `sclk` rising edge that follows the 13th falling edge (12 and 10 bits) or the 11th falling edge (8 bits).
- R7: When `cs_n` rises after at least RES_BITS+4 falling edges, `done` becomes 1 and `aborted` becomes 0. With fewer edges `aborted` becomes 1 and `done` becomes 0. Both hold their values until the next select falling edge.
- R8: `sclk` edges while `cs_n` is high change no output.
- R9: The falling-edge count stops at 16. Further edges in the same frame leave `sdo_oe` at 0, and the frame still ends as complete.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select, synchronous to clk |
| sclk | input | 1 | Serial clock, synchronous to clk |
| sample_word | input | RES_BITS | Parallel sample captured at select |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for three-state drive |
| hold | output | 1 | 1 = hold, 0 = track |
| done | output | 1 | Conversion completed |
| aborted | output | 1 | Conversion ended early |

## Verification
The bench builds three instances side by side with RES_BITS set to 12, 10 and 8, and drives all three with the same select, clock and sample stimulus. This shows the different hold-release points (13 against 11) and the different completion thresholds (16, 14 and 12) under one stimulus. For example, a 13-edge frame is aborted at 12 and 10 bits but complete at 8 bits. It also makes the 10-bit gap, where hold is released but the conversion is still short, observable at the ports.

// File: rtl/adc_shift_pkg.sv
package adc_shift_pkg;
  localparam int FRAME_BITS = 16;
  localparam int LEAD_BITS  = 4;
  localparam int MAX_RES    = 12;

  // Falling edge after which the next rising edge returns to track.
  function automatic int release_edge(int res);
    return (res <= 8) ? 11 : 13;
  endfunction

  // Falling edges needed for a conversion to count as complete.
  function automatic int min_edges(int res);
    return res + LEAD_BITS;
  endfunction

  // Frame as shifted out, MSB leaves first.
  function automatic logic [FRAME_BITS-1:0] build_frame(logic [MAX_RES-1:0] w, int res);
    return FRAME_BITS'(w) << (MAX_RES - res);
  endfunction
endpackage

// File: rtl/edge_sense.sv
module edge_sense #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= din;
  end

  assign rise = din & ~prev;
  assign fall = ~din & prev;
endmodule

// File: rtl/fall_counter.sv
module fall_counter #(
  parameter int LIMIT = 16,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

  assign full = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear)          cnt <= '0;
    else if (step && !full)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] frame_in,
  output logic             msb
);
  logic [WIDTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= frame_in;
    else if (shift) sr <= {sr[WIDTH-2:0], 1'b0};
  end

  assign msb = sr[WIDTH-1];
endmodule

// File: rtl/adc_shift_model.sv
module adc_shift_model #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] sample_word,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                hold,
  output logic                done,
  output logic                aborted
);
  import adc_shift_pkg::*;

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] REL_CNT  = CNT_W'(release_edge(RES_BITS));
  localparam logic [CNT_W-1:0] MIN_CNT  = CNT_W'(min_edges(RES_BITS));
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);

  // Edge detection for select (index 0) and serial clock (index 1).
  logic [1:0] raw_in, rise_v, fall_v;
  assign raw_in = {sclk, cs_n};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    edge_sense #(.IDLE(1'b1)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .rise (rise_v[g]),
      .fall (fall_v[g])
    );
  end

  // Named events, shared with the checker.
  logic cs_fall, cs_rise, sclk_fall_act, sclk_rise_act;
  assign cs_fall       = fall_v[0];
  assign cs_rise       = rise_v[0];
  assign sclk_fall_act = fall_v[1] & ~cs_n & ~cs_fall;
  assign sclk_rise_act = rise_v[1] & ~cs_n & ~cs_fall;

  logic [CNT_W-1:0] edge_cnt;
  logic             cnt_full;

  fall_counter #(.LIMIT(FRAME_BITS)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(cs_fall),
    .step (sclk_fall_act),
    .cnt  (edge_cnt),
    .full (cnt_full)
  );

  logic [FRAME_BITS-1:0] load_frame;
  logic                  frame_msb;
  assign load_frame = build_frame(MAX_RES'(sample_word), RES_BITS);

  frame_shifter #(.WIDTH(FRAME_BITS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cs_fall),
    .shift   (sclk_fall_act & ~cnt_full),
    .frame_in(load_frame),
    .msb     (frame_msb)
  );

  logic last_fall, release_pt, enough;
  assign last_fall  = sclk_fall_act && (edge_cnt == LAST_CNT);
  assign release_pt = sclk_rise_act && (edge_cnt >= REL_CNT);
  assign enough     = (edge_cnt >= MIN_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_oe  <= 1'b0;
      hold    <= 1'b0;
      done    <= 1'b0;
      aborted <= 1'b0;
    end else if (cs_fall) begin
      sdo_oe  <= 1'b1;
      hold    <= 1'b1;
      done    <= 1'b0;
      aborted <= 1'b0;
    end else if (cs_rise) begin
      sdo_oe  <= 1'b0;
      hold    <= 1'b0;
      done    <= enough;
      aborted <= ~enough;
    end else begin
      if (last_fall)  sdo_oe <= 1'b0;
      if (release_pt) hold   <= 1'b0;
    end
  end

  assign sdo = sdo_oe & frame_msb;
endmodule

// File: rtl/adc_shift_checker.sv
module adc_shift_checker #(
  parameter int CNT_W = 5,
  parameter int LIMIT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic             sclk_fall_act,
  input logic [CNT_W-1:0] edge_cnt,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             hold,
  input logic             done,
  input logic             aborted
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(LIMIT);

  AST_SELECT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_oe && hold && !done && !aborted)); // R1
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !sdo); // R2
  AST_SIXTEENTH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall_act && edge_cnt == LAST) |=> !sdo_oe); // R4
  AST_DESELECT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!sdo_oe && !hold)); // R5
  AST_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (done != aborted)); // R7
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(edge_cnt)); // R8
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= TOP); // R9
endmodule

bind adc_shift_model adc_shift_checker #(.CNT_W(CNT_W), .LIMIT(adc_shift_pkg::FRAME_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .cs_fall      (cs_fall),
  .cs_rise      (cs_rise),
  .sclk_fall_act(sclk_fall_act),
  .edge_cnt     (edge_cnt),
  .sdo          (sdo),
  .sdo_oe       (sdo_oe),
  .hold         (hold),
  .done         (done),
  .aborted      (aborted)
);

// File: tb/tb_adc_shift_model.sv
module tb_adc_shift_model;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cs_n, sclk;
  logic [11:0] word;
  logic [2:0]  sdo_v, oe_v, hold_v, done_v, ab_v;

  adc_shift_model #(.RES_BITS(12)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_word(word),
    .sdo(sdo_v[0]), .sdo_oe(oe_v[0]), .hold(hold_v[0]), .done(done_v[0]), .aborted(ab_v[0]));
  adc_shift_model #(.RES_BITS(10)) dut10 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_word(word[9:0]),
    .sdo(sdo_v[1]), .sdo_oe(oe_v[1]), .hold(hold_v[1]), .done(done_v[1]), .aborted(ab_v[1]));
  adc_shift_model #(.RES_BITS(8)) dut8 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_word(word[7:0]),
    .sdo(sdo_v[2]), .sdo_oe(oe_v[2]), .hold(hold_v[2]), .done(done_v[2]), .aborted(ab_v[2]));

  localparam int RESV [3] = '{12, 10, 8};
  localparam int RELV [3] = '{13, 13, 11};

  typedef struct packed { logic [11:0] w; logic [4:0] falls; } vec_t;
  localparam vec_t VECS [8] = '{
    '{12'hA5C, 5'd16}, '{12'hFFF, 5'd16}, '{12'h001, 5'd16}, '{12'h8F3, 5'd14},
    '{12'h3C3, 5'd12}, '{12'h7E1, 5'd5},  '{12'hFFF, 5'd20}, '{12'h96A, 5'd13}};

  int nchecks = 0, nfail = 0;
  int k = 0;
  logic        sel = 1'b0;
  logic [11:0] capw = '0;
  logic [2:0]  eh = '0, edone = '0, eab = '0;

  function automatic logic frame_bit(int res, logic [11:0] w, int idx);
    if (idx < 4) return 1'b0;
    if (idx < 4 + res) return w[res - 1 - (idx - 4)];
    return 1'b0;
  endfunction

  task automatic check(string req, string what, int i, logic act, logic exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s res=%0d actual=%b expected=%b k=%0d", req, what, RESV[i], act, exp, k);
    end
  endtask

  task automatic check_all(string req);
    logic eoe;
    eoe = sel && (k < 16);
    for (int i = 0; i < 3; i++) begin
      check(req, "sdo",     i, sdo_v[i],  eoe && frame_bit(RESV[i], capw, k));
      check(req, "sdo_oe",  i, oe_v[i],   eoe);
      check(req, "hold",    i, hold_v[i], eh[i]);
      check(req, "done",    i, done_v[i], edone[i]);
      check(req, "aborted", i, ab_v[i],   eab[i]);
    end
  endtask

  // Caller is at a negedge; inputs settle, one posedge passes, back at a negedge.
  task automatic apply(logic c, logic s);
    cs_n = c; sclk = s;
    @(negedge clk);
  endtask

  task automatic begin_frame(logic [11:0] w);
    word = w;
    apply(1'b0, 1'b1);
    sel = 1'b1; k = 0; capw = w; eh = '1; edone = '0; eab = '0;
    word = ~w; // R1: later input changes must not reach the frame
    check_all("R1 R2");
  endtask

  task automatic clock_pair();
    apply(1'b0, 1'b0);
    if (k < 16) k++;
    check_all("R2 R3 R4 R9");
    apply(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) if (k >= RELV[i]) eh[i] = 1'b0;
    check_all("R6");
  endtask

  task automatic end_frame();
    apply(1'b1, 1'b1);
    sel = 1'b0; eh = '0;
    for (int i = 0; i < 3; i++) begin
      edone[i] = (k >= RESV[i] + 4);
      eab[i]   = !(k >= RESV[i] + 4);
    end
    check_all("R5 R7");
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; word = '0;
    @(negedge clk); @(negedge clk);
    check_all("R10");
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[v]) begin
      begin_frame(VECS[v].w);
      for (int n = 0; n < int'(VECS[v].falls); n++) clock_pair();
      end_frame();
    end

    // R8: serial clock activity while deselected is ignored
    for (int n = 0; n < 6; n++) begin
      apply(1'b1, 1'b0); check_all("R8");
      apply(1'b1, 1'b1); check_all("R8");
    end

    // R5: early deselect drops enable immediately, also mid-data
    begin_frame(12'h5A5);
    for (int n = 0; n < 7; n++) clock_pair();
    end_frame();

    // R10: reset mid-frame clears everything
    begin_frame(12'hC3F);
    for (int n = 0; n < 9; n++) clock_pair();
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1;
    @(negedge clk);
    sel = 1'b0; k = 0; eh = '0; edone = '0; eab = '0;
    check_all("R10");
    rst_n = 1'b1;
    @(negedge clk);

    // Fresh full frame after reset
    begin_frame(12'h0F0);
    for (int n = 0; n < 16; n++) clock_pair();
    end_frame();

    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule